// File: doc/BRIEF.md
# Ping-Pong Block Buffer Controller

This block sits in front of a pair of block encoders. It takes serial input blocks one symbol per accepted cycle and writes them into one of two symbol banks. Meanwhile it reads the other bank out twice per output cycle: once at a sequential address for the straight path, and once at a permuted address for the interleaved path. The permuted address comes from an outside address generator. The two banks alternate, so loading and unloading overlap. One block can be loaded while the previous block is being read, and the two operations may last different numbers of cycles.

The load side is a three-state machine named LD_IDLE, LD_FILL and LD_HOLD:
- LD_IDLE moves to LD_FILL on a valid start.
- LD_FILL returns to LD_IDLE on the last symbol if the next bank is empty. If the next bank is still waiting to be read out, it goes to LD_HOLD instead.
- LD_HOLD returns to LD_IDLE once that bank has been emptied.

The unload side has two states, UL_IDLE and UL_RUN:
- UL_IDLE moves to UL_RUN when the read bank holds a complete block.
- UL_RUN returns to UL_IDLE after the last symbol of the block has been read, and then switches to the other bank.

A bank is marked full when its load completes. It is marked empty when its last symbol is read. The bank depth is a power-of-two parameter that must cover the largest block size in use.

Top module: `pp_block_buffer`

## Requirements
- R1: A valid start is an active edge where `ce` is high, the controller is in LD_IDLE (`rdy_first` high), and both `first_in` and `new_in` are high. On that edge `size_in` and the first symbol `bit_in` (block index 0) are captured, and `rdy_first` is low from the next cycle.
- R2: In LD_FILL, an edge with `new_in` low neither stores a symbol nor advances the write index. Symbol k of a block is the k-th symbol accepted since its start.
- R3: `size_ok` is 1 when the size captured at the most recent valid start lies between 40 and 5114 inclusive, and 0 otherwise. It changes only on a valid start or a clear.
- R4: `rdy_data` goes low on the edge that accepts the last symbol of a block only if the other bank still holds an unread block (LD_HOLD). Otherwise it stays high.
- R5: `rdy_first` rises only once the bank targeted by the next load has had its previous block fully read out. When leaving LD_HOLD, `rdy_first` and `rdy_data` rise together.
- R6: Blocks go into bank 0, then bank 1, and so on alternately. They are read out in the same order, each with exactly its own captured length, and the straight output carries the block's symbols in index order.
- R7: An output cycle happens on an edge where `ce`, `dn_ready` and `perm_vld` are high in UL_RUN. The next cycle `out_vld` is 1, `out_straight` is symbol k of the block, and `out_perm` is the symbol at index `perm_addr`. An edge with `dn_ready` high and no output cycle makes `out_vld` 0.
- R8: While `dn_ready` is low, `out_vld`, `out_straight`, `out_perm` and the unload state are held. The load side keeps running.
- R9: While `ce` is low every register holds, and `sclr` is ignored.
- R10: `sclr` high on an edge with `ce` high clears the controller: `rdy_first`=1, `rdy_data`=1, `size_ok`=0, `out_vld`=0, both banks empty, and bank 0 becomes the next load target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable; low holds all state |
| sclr | input | 1 | Synchronous clear, qualified by `ce` |
| first_in | input | 1 | Marks the first symbol of a block |
| new_in | input | 1 | Qualifies `bit_in` as a new symbol |
| size_in | input | SW | Block length, captured on a valid start |
| bit_in | input | CH | Input symbol, one bit per channel |
| rdy_first | output | 1 | Ready to begin a new block |
| rdy_data | output | 1 | Ready to accept symbols |
| size_ok | output | 1 | Last captured size lies in 40..5114 |
| perm_addr | input | AW | Permuted read index for the interleaved path |
| perm_vld | input | 1 | `perm_addr` is valid this cycle |
| dn_ready | input | 1 | Downstream ready; low freezes the output side |
| out_vld | output | 1 | Output symbols are valid |
| out_straight | output | CH | Symbol read at the sequential index |
| out_perm | output | CH | Symbol read at the permuted index |

## Verification
The bench alternates short and full-depth blocks while stalling the output, so that one load finishes while the other bank is still unread. A controller that ignored bank occupancy would overwrite an unread block and corrupt its straight output, or it would raise `rdy_first` early. The bench also drops `new_in`, `perm_vld` and `dn_ready` at random; a design that advanced an index on any of these would shift the output symbols by one. Other runs hold `ce` low while pulsing `sclr`, which catches a clear that leaks past the enable. Boundary sizes 39, 40, 5114 and 5115 check the range flag at both ends of the valid range.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int unsigned SIZE_MIN = 40;
    localparam int unsigned SIZE_MAX = 5114;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_HOLD = 2'd2
    } ld_state_t;

    typedef enum logic {
        UL_IDLE = 1'b0,
        UL_RUN  = 1'b1
    } ul_state_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int CH    = 1,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CH-1:0] wdata,
    input  logic [AW-1:0] raddr_seq,
    input  logic [AW-1:0] raddr_prm,
    output logic [CH-1:0] rdata_seq,
    output logic [CH-1:0] rdata_prm
);
    logic [CH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // the permuted port is read-only
    assign rdata_seq = store[raddr_seq];
    assign rdata_prm = store[raddr_prm];
endmodule

// File: rtl/pp_load_ctrl.sv
module pp_load_ctrl
    import pp_pkg::*;
#(
    parameter int SW = 13,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          ce,
    input  logic          sclr,
    input  logic          first_in,
    input  logic          new_in,
    input  logic [SW-1:0] size_in,
    input  logic [1:0]    bank_full,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wbank,
    output logic          fd_hit,
    output logic          load_done,
    output logic          rdy_first,
    output logic          rdy_data,
    output logic          size_ok
);
    localparam logic [SW-1:0] ONE = SW'(1);
    localparam logic [SW-1:0] LO  = SW'(SIZE_MIN);
    localparam logic [SW-1:0] HI  = SW'(SIZE_MAX);

    ld_state_t     state, state_nxt;
    logic [SW-1:0] cnt, len;
    logic          wbank_q, size_ok_q, fill_hit;

    always_comb begin
        state_nxt = state;
        unique case (state)
            LD_IDLE: if (fd_hit) state_nxt = LD_FILL;
            LD_FILL: if (load_done) state_nxt = bank_full[~wbank_q] ? LD_HOLD : LD_IDLE;
            LD_HOLD: if (!bank_full[wbank_q]) state_nxt = LD_IDLE;
            default: state_nxt = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            if (sclr) begin
                state     <= LD_IDLE;
                cnt       <= '0;
                len       <= '0;
                wbank_q   <= 1'b0;
                size_ok_q <= 1'b0;
            end else begin
                state <= state_nxt;
                if (fd_hit) begin
                    cnt       <= ONE;
                    len       <= size_in;
                    size_ok_q <= (size_in >= LO) && (size_in <= HI);
                end else if (fill_hit) begin
                    cnt <= cnt + ONE;
                end
                if (load_done) wbank_q <= ~wbank_q;
            end
        end
    end

    always_comb begin
        fd_hit    = (state == LD_IDLE) && first_in && new_in;
        fill_hit  = (state == LD_FILL) && new_in;
        load_done = fill_hit && (cnt == len - ONE);
        wr_en     = fd_hit || fill_hit;
        wr_addr   = fd_hit ? '0 : cnt[AW-1:0];
        wbank     = wbank_q;
        rdy_first = (state == LD_IDLE);
        rdy_data  = (state != LD_HOLD);
        size_ok   = size_ok_q;
    end
endmodule

// File: rtl/pp_unload_ctrl.sv
module pp_unload_ctrl
    import pp_pkg::*;
#(
    parameter int SW = 13,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          ce,
    input  logic          sclr,
    input  logic          dn_ready,
    input  logic          perm_vld,
    input  logic [1:0]    bank_full,
    input  logic [SW-1:0] bank_len,
    output logic          rbank,
    output logic [AW-1:0] seq_addr,
    output logic          take,
    output logic          unload_done,
    output logic          out_vld
);
    localparam logic [SW-1:0] ONE = SW'(1);

    ul_state_t     state, state_nxt;
    logic [SW-1:0] cnt;
    logic          rbank_q, vld_q, last;

    always_comb begin
        state_nxt = state;
        unique case (state)
            UL_IDLE: if (bank_full[rbank_q]) state_nxt = UL_RUN;
            UL_RUN:  if (take && last) state_nxt = UL_IDLE;
            default: state_nxt = UL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            if (sclr) begin
                state   <= UL_IDLE;
                cnt     <= '0;
                rbank_q <= 1'b0;
                vld_q   <= 1'b0;
            end else if (dn_ready) begin
                state <= state_nxt;
                vld_q <= take;
                if (state == UL_IDLE) cnt <= '0;
                else if (take)        cnt <= cnt + ONE;
                if (unload_done) rbank_q <= ~rbank_q;
            end
        end
    end

    always_comb begin
        take        = (state == UL_RUN) && perm_vld;
        last        = (cnt == bank_len - ONE);
        unload_done = take && last && dn_ready;
        seq_addr    = cnt[AW-1:0];
        rbank       = rbank_q;
        out_vld     = vld_q;
    end
endmodule

// File: rtl/pp_block_buffer.sv
module pp_block_buffer #(
    parameter int CH    = 1,
    parameter int DEPTH = 128,
    parameter int SW    = 13,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ce,
    input  logic          sclr,
    input  logic          first_in,
    input  logic          new_in,
    input  logic [SW-1:0] size_in,
    input  logic [CH-1:0] bit_in,
    output logic          rdy_first,
    output logic          rdy_data,
    output logic          size_ok,
    input  logic [AW-1:0] perm_addr,
    input  logic          perm_vld,
    input  logic          dn_ready,
    output logic          out_vld,
    output logic [CH-1:0] out_straight,
    output logic [CH-1:0] out_perm
);
    logic          act;
    logic          wr_en, wbank, fd_hit, load_done;
    logic [AW-1:0] wr_addr, seq_addr;
    logic          rbank, take, unload_done;
    logic [1:0]    full;
    logic [SW-1:0] len_q [2];
    logic [CH-1:0] rd_seq [2];
    logic [CH-1:0] rd_prm [2];

    assign act = ce && !sclr;

    pp_load_ctrl #(.SW(SW), .AW(AW)) u_load (
        .clk(clk), .ce(ce), .sclr(sclr), .first_in(first_in), .new_in(new_in),
        .size_in(size_in), .bank_full(full), .wr_en(wr_en), .wr_addr(wr_addr),
        .wbank(wbank), .fd_hit(fd_hit), .load_done(load_done),
        .rdy_first(rdy_first), .rdy_data(rdy_data), .size_ok(size_ok)
    );

    pp_unload_ctrl #(.SW(SW), .AW(AW)) u_unload (
        .clk(clk), .ce(ce), .sclr(sclr), .dn_ready(dn_ready), .perm_vld(perm_vld),
        .bank_full(full), .bank_len(len_q[rbank]), .rbank(rbank), .seq_addr(seq_addr),
        .take(take), .unload_done(unload_done), .out_vld(out_vld)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic BID = 1'(b);
        pp_bank #(.CH(CH), .DEPTH(DEPTH), .AW(AW)) u_bank (
            .clk(clk), .we(act && wr_en && (wbank == BID)), .waddr(wr_addr),
            .wdata(bit_in), .raddr_seq(seq_addr), .raddr_prm(perm_addr),
            .rdata_seq(rd_seq[b]), .rdata_prm(rd_prm[b])
        );
    end

    // occupancy and per-bank length
    always_ff @(posedge clk) begin
        if (ce) begin
            if (sclr) begin
                full     <= 2'b00;
                len_q[0] <= '0;
                len_q[1] <= '0;
            end else begin
                if (load_done)   full[wbank]  <= 1'b1;
                if (unload_done) full[rbank]  <= 1'b0;
                if (fd_hit)      len_q[wbank] <= size_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            if (sclr) begin
                out_straight <= '0;
                out_perm     <= '0;
            end else if (dn_ready && take) begin
                out_straight <= rd_seq[rbank];
                out_perm     <= rd_prm[rbank];
            end
        end
    end
endmodule

// File: rtl/pp_block_buffer_chk.sv
module pp_block_buffer_chk #(
    parameter int CH = 1
) (
    input logic          clk,
    input logic          ce,
    input logic          sclr,
    input logic          first_in,
    input logic          new_in,
    input logic          perm_vld,
    input logic          dn_ready,
    input logic          rdy_first,
    input logic          rdy_data,
    input logic          size_ok,
    input logic          out_vld,
    input logic [CH-1:0] out_straight,
    input logic [CH-1:0] out_perm
);
    logic rst_q;

    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_r10: assert (rdy_first && rdy_data && !size_ok && !out_vld)
                else $error("clear did not restore idle outputs");
        end
        rst_q <= ce && sclr;
    end

    p_fd_drop_r1: assert property (@(posedge clk) disable iff (sclr)
        (ce && rdy_first && first_in && new_in) |=> !rdy_first)
        else $error("rdy_first stayed high after a start");

    p_size_stable_r3: assert property (@(posedge clk) disable iff (sclr)
        (!(ce && rdy_first && first_in && new_in)) |=> $stable(size_ok))
        else $error("size_ok changed without a start");

    p_leave_hold_r5: assert property (@(posedge clk) disable iff (sclr)
        $rose(rdy_data) |-> rdy_first)
        else $error("rdy_data rose without rdy_first");

    p_no_pass_r7: assert property (@(posedge clk) disable iff (sclr)
        (ce && dn_ready && !perm_vld) |=> !out_vld)
        else $error("out_vld without permuted address");

    p_frozen_r8: assert property (@(posedge clk) disable iff (sclr)
        (ce && !dn_ready) |=> ($stable(out_vld) && $stable(out_straight) && $stable(out_perm)))
        else $error("output side moved while stalled");

    p_ce_hold_r9: assert property (@(posedge clk) disable iff (sclr)
        (!ce) |=> ($stable(rdy_first) && $stable(rdy_data) && $stable(size_ok) && $stable(out_vld)))
        else $error("state moved with ce low");
endmodule

bind pp_block_buffer pp_block_buffer_chk #(.CH(CH)) u_chk (
    .clk(clk), .ce(ce), .sclr(sclr), .first_in(first_in), .new_in(new_in),
    .perm_vld(perm_vld), .dn_ready(dn_ready), .rdy_first(rdy_first),
    .rdy_data(rdy_data), .size_ok(size_ok), .out_vld(out_vld),
    .out_straight(out_straight), .out_perm(out_perm)
);

// File: tb/sim_pp_block_buffer.sv
module sim_pp_block_buffer;
    localparam int CH = 1, DEPTH = 128, SW = 13, AW = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          ce, sclr, first_in, new_in, perm_vld, dn_ready;
    logic [SW-1:0] size_in;
    logic [CH-1:0] bit_in;
    logic [AW-1:0] perm_addr;
    logic          rdy_first, rdy_data, size_ok, out_vld;
    logic [CH-1:0] out_straight, out_perm;

    pp_block_buffer #(.CH(CH), .DEPTH(DEPTH), .SW(SW)) u0 (
        .clk(clk), .ce(ce), .sclr(sclr), .first_in(first_in), .new_in(new_in),
        .size_in(size_in), .bit_in(bit_in), .rdy_first(rdy_first), .rdy_data(rdy_data),
        .size_ok(size_ok), .perm_addr(perm_addr), .perm_vld(perm_vld), .dn_ready(dn_ready),
        .out_vld(out_vld), .out_straight(out_straight), .out_perm(out_perm)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // drive values for the next edge
    bit d_ce, d_sclr, d_fi, d_ni, d_pv, d_dr;
    int d_sz;
    logic [CH-1:0] d_bi;
    logic [AW-1:0] d_pa;

    // reference model
    int m_ld, m_cnt, m_len, m_wb, m_ul, m_rc, m_rb;
    bit m_sok, m_vld;
    logic [CH-1:0] m_os, m_op;
    bit m_full[2];
    int m_blen[2];
    logic [CH-1:0] m_mem[2][DEPTH];
    int blocks_out = 0;

    // stimulus controls
    int p_ceoff = 0, p_gap = 0, p_stall = 0, p_pvoff = 0, sz_mode = 0;
    bit gen_on = 1, no_start = 0, alt = 0;
    bit frz_prev = 0, ceoff_prev = 0;
    logic [31:0] snap8, snap9;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ld = 0; m_cnt = 0; m_len = 0; m_wb = 0; m_ul = 0; m_rc = 0; m_rb = 0;
        m_sok = 0; m_vld = 0; m_os = '0; m_op = '0;
        m_full[0] = 0; m_full[1] = 0; m_blen[0] = 0; m_blen[1] = 0;
    endtask

    task automatic model_step();
        int  ld0 = m_ld, wb0 = m_wb, rb0 = m_rb, ul0 = m_ul;
        bit  f0[2];
        bit  fd, fill, ldone, take, last;
        f0[0] = m_full[0]; f0[1] = m_full[1];
        if (!d_ce) return;
        if (d_sclr) begin model_reset(); return; end
        fd    = (ld0 == 0) && d_fi && d_ni;
        fill  = (ld0 == 1) && d_ni;
        ldone = fill && (m_cnt == m_len - 1);
        take  = (ul0 == 1) && d_pv;
        last  = (m_rc == m_blen[rb0] - 1);
        if (d_dr) begin
            m_vld = take;
            if (ul0 == 0) begin
                if (f0[rb0]) begin m_ul = 1; m_rc = 0; end
            end else if (take) begin
                m_os = m_mem[rb0][m_rc % DEPTH];
                m_op = m_mem[rb0][d_pa];
                m_rc++;
                if (last) begin m_full[rb0] = 0; m_ul = 0; m_rb = 1 - rb0; blocks_out++; end
            end
        end
        if (fd) begin
            m_mem[wb0][0] = d_bi; m_cnt = 1; m_len = d_sz; m_blen[wb0] = d_sz;
            m_sok = (d_sz >= 40) && (d_sz <= 5114); m_ld = 1;
        end else if (fill) begin
            m_mem[wb0][m_cnt % DEPTH] = d_bi; m_cnt++;
            if (ldone) begin m_full[wb0] = 1; m_wb = 1 - wb0; m_ld = f0[1 - wb0] ? 2 : 0; end
        end else if (ld0 == 2) begin
            if (!f0[wb0]) m_ld = 0;
        end
    endtask

    function automatic int pick_size();
        if (sz_mode == 1) begin alt = !alt; return alt ? 40 : DEPTH; end
        if (sz_mode == 2) return ($urandom_range(3) == 0) ? 39 : int'($urandom_range(DEPTH, 40));
        return int'($urandom_range(DEPTH, 40));
    endfunction

    task automatic gen_inputs();
        d_ce   = ($urandom_range(99) >= p_ceoff);
        d_sclr = (p_ceoff > 0) && !d_ce && ($urandom_range(99) < 30);
        d_fi = 0; d_ni = 0;
        if (m_ld == 0 && !no_start && $urandom_range(99) < 60) begin
            d_fi = 1; d_ni = 1; d_sz = pick_size();
        end else if (m_ld == 1) begin
            d_ni = ($urandom_range(99) >= p_gap);
        end else begin
            d_ni = 1'($urandom_range(1));
        end
        d_bi = CH'($urandom_range(1));
        d_pv = ($urandom_range(99) >= p_pvoff);
        d_dr = ($urandom_range(99) >= p_stall);
        d_pa = (m_ul == 1) ? AW'($urandom_range(m_blen[m_rb] - 1)) : AW'($urandom_range(DEPTH - 1));
    endtask

    task automatic compare_all();
        chk("R1 R5 rdy_first", 32'(rdy_first), 32'(m_ld == 0));
        chk("R4 rdy_data", 32'(rdy_data), 32'(m_ld != 2));
        chk("R3 size_ok", 32'(size_ok), 32'(m_sok));
        chk("R7 out_vld", 32'(out_vld), 32'(m_vld));
        if (m_vld) begin
            chk("R2 R6 straight", 32'(out_straight), 32'(m_os));
            chk("R7 perm", 32'(out_perm), 32'(m_op));
        end
        if (frz_prev)   chk("R8 frozen", {out_vld, out_straight, out_perm}, snap8);
        if (ceoff_prev) chk("R9 hold", {rdy_first, rdy_data, size_ok, out_vld}, snap9);
        snap8 = {out_vld, out_straight, out_perm};
        snap9 = {rdy_first, rdy_data, size_ok, out_vld};
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        if (gen_on) gen_inputs();
        ce = d_ce; sclr = d_sclr; first_in = d_fi; new_in = d_ni; size_in = SW'(d_sz);
        bit_in = d_bi; perm_vld = d_pv; dn_ready = d_dr; perm_addr = d_pa;
        frz_prev   = d_ce && !d_sclr && !d_dr;
        ceoff_prev = !d_ce;
        model_step();
    endtask

    task automatic set_phase(int ceoff, int gap, int stall, int pvoff, int mode);
        p_ceoff = ceoff; p_gap = gap; p_stall = stall; p_pvoff = pvoff; sz_mode = mode;
    endtask

    task automatic probe_size(int sz, bit expok);
        set_phase(0, 0, 0, 0, 0);
        gen_on = 1; no_start = 1;
        while (m_ld != 0) tick();
        gen_on = 0;
        d_ce = 1; d_sclr = 0; d_fi = 1; d_ni = 1; d_sz = sz; d_bi = '1; d_pv = 0; d_dr = 1;
        tick();
        d_fi = 0; d_ni = 0;
        tick();
        chk("R3 boundary", 32'(size_ok), 32'(expok));
        d_sclr = 1; tick();
        d_sclr = 0; tick();
        chk("R10 after clear", {rdy_first, rdy_data, size_ok, out_vld}, 32'b1100);
        gen_on = 1; no_start = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        d_ce = 1; d_sclr = 1; d_fi = 0; d_ni = 0; d_sz = 0; d_bi = '0; d_pv = 0; d_dr = 1; d_pa = '0;
        ce = 1; sclr = 1; first_in = 0; new_in = 0; size_in = '0; bit_in = '0;
        perm_vld = 0; dn_ready = 1; perm_addr = '0;
        model_reset();
        repeat (2) @(posedge clk);
        gen_on = 0; d_sclr = 0;
        tick();
        chk("R10 reset state", {rdy_first, rdy_data, size_ok, out_vld}, 32'b1100);
        gen_on = 1;

        set_phase(0, 0, 0, 0, 0);   repeat (2000) tick();  // R6 clean streaming
        set_phase(0, 40, 0, 0, 0);  repeat (2000) tick();  // R2 input gaps
        set_phase(0, 0, 50, 0, 0);  repeat (2000) tick();  // R8 output stalls
        set_phase(0, 0, 0, 40, 0);  repeat (2000) tick();  // R7 address gaps
        set_phase(0, 0, 30, 0, 1);  repeat (2500) tick();  // R4 R5 short/long mix
        set_phase(30, 20, 20, 20, 2); repeat (2500) tick(); // R9 ce low with clear pulses

        probe_size(39, 0);
        probe_size(40, 1);
        probe_size(5114, 1);
        probe_size(5115, 0);

        chk("R6 blocks completed", 32'(blocks_out >= 20), 32'd1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule